// File: doc/BRIEF.md
# Shared-Wire Request/Busy Handshake

This block owns one bidirectional wire that carries two messages in opposite directions. An external device asks for work by pulling the wire high. The wire rests low through an external pull-down resistor. The block brings the wire into its clock domain through a synchronizer and can pass it through a glitch filter. It then looks for a low-to-high change and turns that change into a one-clock start strobe for the on-chip processing logic.

While the processing logic reports busy, the block enables its pad driver, which only ever drives the wire high. That keeps the wire high after the external device lets go. When busy drops, the driver goes high-impedance and the pull-down takes the wire low, which tells the device the job is done. The busy input must rise before the device stops driving, so that the wire never dips low between request and completion.

The filter length `FILT_LEN` sets how many consecutive clock samples a new level must last before it is believed. A value of 0 removes the filter. The pad itself and the processing engine sit outside this block. The pad's data input is tied high, and `pinOe` is its enable.

Top module: `wire_handshake`

## Requirements
- R1: `rst` is synchronous and active high. In the cycle after any clock edge that samples `rst` high, `startPulse` and `pinOe` are 0. The synchronizer, filter and previous-level registers also clear to 0.
- R2: Take `FILT_LEN`=N, and let edge k be the first edge that samples `pinIn` high after it has been low and settled. If the filter accepts the new level, `startPulse` is 1 exactly in the cycle that follows edge k+N+2.
- R3: Each accepted low-to-high change gives exactly one `startPulse` cycle, and `startPulse` is never 1 in two consecutive cycles.
- R4: `pinOe` is 1 in the cycle after an edge that samples `busy` as 1, and 0 in the cycle after an edge that samples it as 0.
- R5: With N>0, a high level on `pinIn` that lasts fewer than N consecutive clock samples produces no `startPulse`.
- R6: With N>0, a high level that lasts N consecutive clock samples is accepted and produces one pulse.
- R7: While the wire stays high, including when only the block's own driver holds it, no further `startPulse` occurs. A new pulse requires the accepted level to go low first.
- R8: With N=0 the filter is bypassed. Every rising sampled level, however short, gives a pulse 2 edges after it is first sampled.
- R9: With N>0, a low dip in a held-high wire that lasts fewer than N samples is ignored and does not re-arm the detector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pinIn | input | 1 | Sampled level of the shared wire, asynchronous |
| busy | input | 1 | Processing logic reports work in progress |
| pinOe | output | 1 | Pad driver enable; the pad drives high when set |
| startPulse | output | 1 | One-cycle request strobe to the processing logic |

## Verification
A wire high first sampled at edge k is due as `startPulse` after edge k+N+2. The N+2 comes from two synchronizer flops, N filter samples, and one output register, with the edge compare sitting in front of that register. `pinOe` follows `busy` one edge later. The bench keeps a history of the samples it took at each rising edge and works out every due value from the history with those offsets. It compares both outputs of a filtered and an unfiltered instance at the falling edge of every cycle. Explicit pulse counts over each scenario then confirm the glitch, dip and self-hold cases.

// File: rtl/hs_pkg.sv
package hs_pkg;

  // Filtered wire state reported by the datapath to the control.
  typedef struct packed {
    logic level;
    logic rise;
  } lineEvt_t;

  // Strobes issued by the control toward the block edge.
  typedef struct packed {
    logic startStb;
    logic driveStb;
  } ctrlStb_t;

endpackage

// File: rtl/hs_datapath.sv
module hs_datapath
  import hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     pinIn,
  output lineEvt_t evt
);

  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic syncLvl;
  logic filtLvl;
  logic prevLvl;

  // Synchronizer chain for the asynchronous wire.
  always_ff @(posedge clk) begin
    if (rst) syncQ <= '0;
    else     syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
  end
  assign syncLvl = syncQ[SYNC_STAGES-1];

  generate
    if (FILT_LEN == 0) begin : g_bypass
      assign filtLvl = syncLvl;
    end else begin : g_filter
      logic [CNT_W-1:0] runCnt;
      logic stableLvl;

      always_ff @(posedge clk) begin
        if (rst) begin
          runCnt    <= '0;
          stableLvl <= 1'b0;
        end else if (syncLvl != stableLvl) begin
          if (runCnt == CNT_W'(FILT_LEN - 1)) begin
            stableLvl <= syncLvl;
            runCnt    <= '0;
          end else begin
            runCnt <= runCnt + 1'b1;
          end
        end else begin
          runCnt <= '0;
        end
      end
      assign filtLvl = stableLvl;

      // R5
      filt_follows_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && stableLvl != $past(stableLvl)) |-> stableLvl == $past(syncLvl));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prevLvl <= 1'b0;
    else     prevLvl <= filtLvl;
  end

  assign evt.level = filtLvl;
  assign evt.rise  = filtLvl & ~prevLvl;

  // R7
  rise_rearms_chk: assert property (@(posedge clk) disable iff (rst)
    evt.rise |=> prevLvl);

endmodule

// File: rtl/hs_control.sv
module hs_control
  import hs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  lineEvt_t evt,
  input  logic     busy,
  output ctrlStb_t stb
);

  logic startQ;
  logic driveQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      startQ <= 1'b0;
      driveQ <= 1'b0;
    end else begin
      startQ <= evt.rise;
      driveQ <= busy;
    end
  end

  assign stb.startStb = startQ;
  assign stb.driveStb = driveQ;

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    stb.startStb |=> !stb.startStb);

  // R4
  drive_follows_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stb.driveStb == $past(busy));

endmodule

// File: rtl/wire_handshake.sv
module wire_handshake
  import hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pinIn,
  input  logic busy,
  output logic pinOe,
  output logic startPulse
);

  lineEvt_t evt;
  ctrlStb_t stb;

  hs_datapath #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_dp (
    .clk(clk), .rst(rst), .pinIn(pinIn), .evt(evt)
  );

  hs_control u_ctl (
    .clk(clk), .rst(rst), .evt(evt), .busy(busy), .stb(stb)
  );

  assign pinOe      = stb.driveStb;
  assign startPulse = stb.startStb;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!startPulse && !pinOe));

endmodule

// File: tb/wire_handshake_bench.sv
`timescale 1ns/1ps
module wire_handshake_bench;

  localparam int NF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic extDrv = 1'b0;
  logic busy = 1'b0;
  logic pinOeA, startA, pinOeB, startB;
  logic wireLvl;

  int tests = 0;
  int fails = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  // Wire: external driver or the filtered instance's pad driver; pull-down otherwise.
  assign wireLvl = extDrv | pinOeA;

  wire_handshake #(.FILT_LEN(NF)) u_wire_handshake (
    .clk(clk), .rst(rst), .pinIn(wireLvl), .busy(busy),
    .pinOe(pinOeA), .startPulse(startA)
  );

  wire_handshake #(.FILT_LEN(0)) u_wire_handshake_nf (
    .clk(clk), .rst(rst), .pinIn(wireLvl), .busy(busy),
    .pinOe(pinOeB), .startPulse(startB)
  );

  // Reference model: sample history taken at each rising edge.
  logic [15:0] pinH = '0;
  logic [3:0]  lvlA = '0;
  logic [3:0]  lvlB = '0;
  logic expStartA = 1'b0, expStartB = 1'b0, expOe = 1'b0;

  function automatic logic windowLevel(logic [15:0] h, int n, logic cur);
    logic v = h[2];
    for (int i = 2; i < n + 2; i++) if (h[i] != v) return cur;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      pinH = '0; lvlA = '0; lvlB = '0;
      expStartA = 0; expStartB = 0; expOe = 0;
    end else begin
      pinH = {pinH[14:0], wireLvl};
      lvlA = {lvlA[2:0], windowLevel(pinH, NF, lvlA[0])};
      lvlB = {lvlB[2:0], pinH[1]};
      expStartA = lvlA[1] & ~lvlA[2];
      expStartB = lvlB[1] & ~lvlB[2];
      expOe = busy;
    end
  end

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  int pulsesA = 0, pulsesB = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      check(tag, startA, expStartA);
      check("R8", startB, expStartB);
      check("R4", pinOeA, expOe);
      check("R4", pinOeB, expOe);
      if (startA) pulsesA++;
      if (startB) pulsesB++;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic countCheck(string req, int actA, int expA, int actB, int expB);
    check(req, actA == expA, 1'b1);
    if (actA != expA) $display("FAIL %s: filtered pulses %0d expected %0d", req, actA, expA);
    check(req, actB == expB, 1'b1);
    if (actB != expB) $display("FAIL %s: bypass pulses %0d expected %0d", req, actB, expB);
  endtask

  task automatic request(int holdExt, int busyLen);
    extDrv = 1; idle(2); busy = 1; idle(holdExt);
    extDrv = 0; idle(busyLen); busy = 0; idle(10);
  endtask

  initial begin
    int a0, b0;
    // R1: reset, with the wire driven during it
    extDrv = 1; busy = 1;
    idle(4);
    extDrv = 0; busy = 0; idle(1);
    rst = 0;
    @(negedge clk); #1;
    check("R1", startA, 1'b0);
    check("R1", pinOeA, 1'b0);
    idle(6);

    // R2 R6 R7: request, self hold while engine busy
    tag = "R2";
    a0 = pulsesA; b0 = pulsesB;
    request(6, 14);
    countCheck("R7", pulsesA - a0, 1, pulsesB - b0, 1);

    // R3: several requests with differing lengths
    tag = "R3";
    a0 = pulsesA; b0 = pulsesB;
    for (int i = 0; i < 3; i++) request(NF + i, 3 + 2 * i);
    countCheck("R3", pulsesA - a0, 3, pulsesB - b0, 3);

    // R5 R8: glitch shorter than NF samples
    tag = "R5";
    a0 = pulsesA; b0 = pulsesB;
    extDrv = 1; idle(NF - 1); extDrv = 0; idle(12);
    countCheck("R5", pulsesA - a0, 0, pulsesB - b0, 1);

    // R6: exactly NF samples high is accepted
    tag = "R6";
    a0 = pulsesA; b0 = pulsesB;
    extDrv = 1; idle(NF); extDrv = 0; idle(12);
    countCheck("R6", pulsesA - a0, 1, pulsesB - b0, 1);

    // R9: short low dip in a held-high wire
    tag = "R9";
    a0 = pulsesA; b0 = pulsesB;
    extDrv = 1; idle(10); extDrv = 0; idle(2); extDrv = 1; idle(10);
    extDrv = 0; idle(12);
    countCheck("R9", pulsesA - a0, 1, pulsesB - b0, 2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule